// File: doc/BRIEF.md
# Restartable Strided Tile Store Engine

This block copies a two-dimensional tile out of a local row-addressable tile buffer into memory, one memory write request per row. When a start pulse arrives, the block takes a base address, a displacement, an index value with a presence flag, a shift amount, a row count and a byte-per-row count. It then presents each row on a valid/ready write port, at an address that moves by a fixed stride from one row to the next.

The walk can be restarted. The block keeps a start-row register and begins each walk at the row that register holds. The register moves forward as rows are accepted. A fault response on an accepted write stops the walk and leaves the register on the row that failed, so that issuing the same request again continues from that row. The register is cleared only when the walk completes. The tile buffer is read combinationally through a row-select output.

Top module: `strided_tile_writer`

## Requirements
- R1: The write address of row r equals base_addr + disp + r * stride, computed modulo 2^64 from the values sampled with the start pulse. Input changes after the start have no effect on the walk.
- R2: The stride is index_val shifted left by scale when index_present is 1, and zero when index_present is 0.
- R3: A walk issues exactly one write for each row from the start-row value up to row_count - 1, in ascending order. tile_row shows the row currently presented.
- R4: wr_bytes equals the sampled row_bytes. Byte k of wr_data (bits 8k+7..8k) carries byte k of tile_data when k < row_bytes and is zero otherwise.
- R5: While wr_valid is high and wr_ready is low, the address, byte count and row stay unchanged. The row advances only on an accepted write that carries no fault.
- R6: After the last row is accepted without a fault, done pulses, busy falls and resume_row reads 0.
- R7: An accepted write with wr_fault high produces a fault pulse, ends the walk with no further writes, and leaves resume_row on the row that faulted.
- R8: A start issued after a fault begins the walk at the saved row.
- R9: A start pulse while busy is ignored.
- R10: If resume_row is at or above row_count when started, no write is issued, done pulses in the next cycle and resume_row is cleared.
- R11: After reset, busy, done, fault and wr_valid are 0 and resume_row is 0. Done and fault never coincide, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| base_addr | input | 64 | Base address |
| disp | input | 64 | Displacement added to the base |
| index_val | input | 64 | Stride index value |
| index_present | input | 1 | Index valid; zero stride when low |
| scale | input | 2 | Left-shift amount applied to the index |
| row_count | input | 5 | Configured row count, 0..16 |
| row_bytes | input | 7 | Configured bytes per row, 0..64 |
| tile_row | output | 4 | Row select into the tile buffer |
| tile_data | input | 512 | Selected tile row, byte k at bits 8k+7..8k |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Row write address |
| wr_bytes | output | 7 | Bytes written for this row |
| wr_data | output | 512 | Row data with bytes past the count zeroed |
| wr_fault | input | 1 | Fault response, qualified by wr_ready |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| resume_row | output | 5 | Start-row register |

## Verification
All four shift amounts are run with and without an index present. This separates the shifted stride from the zero stride. Row counts from 1 to 16 are swept, with byte counts that step through 0..64 and a ready line that stalls every third cycle. This tests the loop bound, the byte masking and how the payload holds under back-pressure. A base near the top of the address space checks that the sum wraps. Faults placed on the first row and on a middle row, each followed by a reissue, and a reissue with the saved row above a reduced row count, test the save, resume and empty-walk paths separately.

// File: rtl/strided_tile_writer.sv
module strided_tile_writer #(
  parameter int ROWS_MAX  = 16,
  parameter int ROW_BYTES = 64,
  parameter int ADDR_W    = 64,
  parameter int SCALE_W   = 2,
  localparam int CNT_W    = $clog2(ROWS_MAX + 1),
  localparam int RIDX_W   = $clog2(ROWS_MAX),
  localparam int BCNT_W   = $clog2(ROW_BYTES + 1),
  localparam int DATA_W   = ROW_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] index_val,
  input  logic              index_present,
  input  logic [SCALE_W-1:0] scale,
  input  logic [CNT_W-1:0]  row_count,
  input  logic [BCNT_W-1:0] row_bytes,
  output logic [RIDX_W-1:0] tile_row,
  input  logic [DATA_W-1:0] tile_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BCNT_W-1:0] wr_bytes,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_fault,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [CNT_W-1:0]  resume_row
);

  logic [ADDR_W-1:0] stride_q, addr_q;
  logic [CNT_W-1:0]  rows_q, cur_q;
  logic [BCNT_W-1:0] bytes_q;
  logic              busy_q, done_q, fault_q;

  wire [ADDR_W-1:0] stride_in = (index_present ? index_val : '0) << scale;
  wire [CNT_W-1:0]  cur_next  = cur_q + 1'b1;
  wire              accept    = busy_q && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stride_q <= '0;
      addr_q   <= '0;
      rows_q   <= '0;
      cur_q    <= '0;
      bytes_q  <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (!busy_q && start) begin
        if (cur_q >= row_count) begin
          done_q <= 1'b1;
          cur_q  <= '0;
        end else begin
          busy_q   <= 1'b1;
          stride_q <= stride_in;
          rows_q   <= row_count;
          bytes_q  <= row_bytes;
          addr_q   <= base_addr + disp + ADDR_W'(cur_q) * stride_in;
        end
      end else if (accept) begin
        if (wr_fault) begin
          fault_q <= 1'b1;
          busy_q  <= 1'b0;
        end else if (cur_next >= rows_q) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          cur_q  <= '0;
        end else begin
          cur_q  <= cur_next;
          addr_q <= addr_q + stride_q;
        end
      end
    end
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_mask
    assign wr_data[8*g +: 8] = (BCNT_W'(g) < bytes_q) ? tile_data[8*g +: 8] : 8'h00;
  end

  assign tile_row   = cur_q[RIDX_W-1:0];
  assign wr_valid   = busy_q;
  assign wr_addr    = addr_q;
  assign wr_bytes   = bytes_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign fault      = fault_q;
  assign resume_row = cur_q;

endmodule

// File: rtl/strided_tile_writer_chk.sv
module strided_tile_writer_chk #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 5,
  parameter int BCNT_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_fault,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BCNT_W-1:0] wr_bytes,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [CNT_W-1:0]  resume_row
);

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R11
  AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) fault |=> !fault); // R11
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_bytes) && $stable(resume_row)); // R5
  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !wr_fault |=>
      (wr_valid && resume_row == $past(resume_row) + 1'b1) || (done && resume_row == '0)); // R6
  AST_FAULT_SAVES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_fault |=> fault && !busy && resume_row == $past(resume_row)); // R7
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !wr_ready |=> busy && $stable(wr_addr)); // R9
  AST_DONE_CLEARS_ROW: assert property (@(posedge clk) disable iff (!rst_n) done |-> resume_row == '0); // R6

endmodule

bind strided_tile_writer strided_tile_writer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BCNT_W(BCNT_W)) u_chk (.*);

// File: tb/strided_tile_writer_test.sv
module strided_tile_writer_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  base_addr = '0, disp = '0, index_val = '0;
  logic         index_present = 1'b0;
  logic [1:0]   scale = '0;
  logic [4:0]   row_count = '0;
  logic [6:0]   row_bytes = '0;
  logic [3:0]   tile_row;
  logic [511:0] tile_data;
  logic         wr_valid, wr_ready = 1'b0, wr_fault = 1'b0;
  logic [63:0]  wr_addr;
  logic [6:0]   wr_bytes;
  logic [511:0] wr_data;
  logic         busy, done, fault;
  logic [4:0]   resume_row;

  int checks = 0;
  int errors = 0;
  int m_resume = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  strided_tile_writer uut (.*);

  function automatic logic [7:0] tbyte(int r, int k);
    return 8'(r * 37 + k * 5 + 3);
  endfunction

  always_comb
    for (int k = 0; k < 64; k++) tile_data[8*k +: 8] = tbyte(int'(tile_row), k);

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic run(input logic [63:0] b, input logic [63:0] d, input logic [63:0] ix,
                     input bit pr, input int sc, input int nr, input int nb,
                     input int fr, input int stall, input bit poke);
    logic [63:0]  stride, ea;
    logic [511:0] ed;
    int row = m_resume;
    int cyc = 0;
    bit acc;
    stride = (pr ? ix : 64'd0) << sc;
    @(negedge clk);
    base_addr = b; disp = d; index_val = ix; index_present = pr;
    scale = 2'(sc); row_count = 5'(nr); row_bytes = 7'(nb); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    base_addr = ~b; disp = 64'h1234; index_val = ~ix; index_present = ~pr; row_bytes = 7'd5;
    if (m_resume >= nr) begin
      chk(done && !busy && !wr_valid, "R10 immediate done", {done, busy, wr_valid}, 3'b100);
      chk(resume_row == 0, "R10 start row cleared", resume_row, 0);
      m_resume = 0;
    end else begin
      for (int it = 0; it < 200; it++) begin
        if (done) begin
          chk(row == nr && !busy && !fault, "R6 completion", row, nr);
          chk(resume_row == 0, "R6 start row cleared", resume_row, 0);
          m_resume = 0;
          break;
        end
        if (fault) begin
          chk(row == fr && !busy && !wr_valid, "R7 fault stop", row, fr);
          chk(resume_row == 5'(fr), "R7 faulted row saved", resume_row, fr);
          m_resume = fr;
          break;
        end
        chk(wr_valid == 1'b1, "R5 valid held while busy", wr_valid, 1);
        ea = b + d + 64'(row) * stride;
        chk(wr_addr == ea, "R1 R2 row address", wr_addr, ea);
        chk(tile_row == 4'(row) && resume_row == 5'(row), "R3 row order", tile_row, row);
        for (int k = 0; k < 64; k++) ed[8*k +: 8] = (k < nb) ? tbyte(row, k) : 8'h00;
        chk(wr_bytes == 7'(nb) && wr_data == ed, "R4 row payload", wr_data, ed);
        acc = (stall == 0) || (cyc % stall != 0);
        wr_ready = acc;
        wr_fault = acc && (row == fr);
        start = poke && (cyc == 2);
        @(negedge clk);
        wr_ready = 1'b0; wr_fault = 1'b0; start = 1'b0;
        if (acc && row != fr) row++;
        cyc++;
      end
    end
    @(negedge clk);
    chk(!done && !fault, "R11 single-cycle pulse", {done, fault}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !wr_valid && resume_row == 0, "R11 reset state",
        {busy, done, fault, wr_valid, resume_row}, 0);
    rst_n = 1'b1;
    // R2 shift amount and index presence sweep
    for (int pr = 0; pr < 2; pr++)
      for (int sc = 0; sc < 4; sc++)
        run(64'h1000 + 64'(sc), 64'h20, 64'h48 + 64'(pr), pr[0], sc, 3, 16, -1, 0, 0);
    // R3 R4 R5 R9 row and byte count sweep with stalls, one busy start
    for (int r = 1; r <= 16; r++)
      run(64'h8000_0000 + 64'(r * 256), 64'hFFFF_FFFF_FFFF_FF00, 64'h100, 1, 1,
          r, (r * 4) % 65, -1, 3, r == 5);
    for (int nb = 0; nb <= 64; nb += 21)
      run(64'h40, 64'h4, 64'h40, 1, 0, 2, nb, -1, 0, 0);
    // R1 wrap modulo 2^64
    run(64'hFFFF_FFFF_FFFF_FFF0, 64'h8, 64'h10, 1, 2, 4, 64, -1, 0, 0);
    // R7 R8 fault mid-walk then resume
    run(64'hA000, 64'h0, 64'h80, 1, 0, 8, 32, 5, 2, 0);
    chk(resume_row == 5, "R8 saved row visible before reissue", resume_row, 5);
    run(64'hA000, 64'h0, 64'h80, 1, 0, 8, 32, -1, 0, 0);
    // R7 fault on the first row
    run(64'hB000, 64'h10, 64'h40, 1, 1, 6, 8, 0, 0, 0);
    run(64'hB000, 64'h10, 64'h40, 1, 1, 6, 8, -1, 2, 0);
    // R10 saved row beyond a reduced row count
    run(64'hC000, 64'h0, 64'h40, 1, 0, 8, 4, 5, 0, 0);
    run(64'hC000, 64'h0, 64'h40, 1, 0, 4, 4, -1, 0, 0);
    run(64'hC000, 64'h0, 64'h40, 1, 0, 3, 4, -1, 0, 0);
    run(64'hD000, 64'h0, 64'h40, 1, 0, 0, 4, -1, 0, 0);
    summary();
  end
endmodule